// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block is a hardware refill engine. It turns a 32-bit virtual address into a physical address by reading a two-level page table held in memory. The address is split into three fields: a top-level index in bits 31..22, a second-level index in bits 21..12, and a page offset in bits 11..0. Pages are 4 KB.

A walk starts with one read of the top-level table, at a configurable base address. If that entry marks a second-level table as present, the walker reads the entry of that table which the second index selects. That entry supplies the frame number. If either entry is absent, the walk ends with a fault that names the level that failed. The walker uses a single read port with a request/response handshake, and the memory may take any number of wait cycles to answer.

The control is a state machine. Its states are IDLE, READ_L1, WAIT_L1, READ_L2, WAIT_L2 and DONE. The transitions are:
- IDLE to READ_L1 when a request arrives.
- READ_L1 to WAIT_L1 after the read is issued.
- WAIT_L1 to READ_L2 when the response carries a present entry.
- WAIT_L1 to DONE when the response carries an absent entry.
- READ_L2 to WAIT_L2 after the read is issued.
- WAIT_L2 to DONE on the response.
- DONE to IDLE unconditionally.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is in IDLE. `req_ready` is 1, and `rsp_done` and `mem_req` are 0.
- R2: The first read of a walk uses the address `base + vaddr[31:22]*4`. Each read is a `mem_req` pulse exactly one cycle long.
- R3: A memory entry is present when bit 0 is 1. Bits 31..12 of an entry hold a table base or a frame number. For a present top-level entry E, the second read uses the address `{E[31:12], 12'h000} + vaddr[21:12]*4`.
- R4: When the second-level entry is present, the result is `rsp_paddr = {entry[31:12], vaddr[11:0]}` with `rsp_fault` = 0, after exactly two reads.
- R5: When the top-level entry is absent, the walk ends after exactly one read. It reports `rsp_fault` = 1 and `rsp_flvl` = 0, and second-level memory is never accessed.
- R6: When the second-level entry is absent, the walk reports `rsp_fault` = 1 and `rsp_flvl` = 1 after two reads. On any fault, `rsp_paddr` is 0.
- R7: The walker accepts any number of wait cycles between a read request and `mem_rvalid`. `mem_rdata` is ignored while `mem_rvalid` is 0.
- R8: `rsp_done` is a single-cycle pulse. The result outputs are valid in that cycle. The next cycle the walker is back in IDLE with `req_ready` = 1.
- R9: A request is accepted only while `req_ready` is 1. `req_valid` during a walk is ignored: it neither changes the walk in progress nor starts a later walk.
- R10: The base register is written only while the walker is idle, and a write during a walk is dropped. A write in the same cycle as an accepted request applies to that request.
- R11: The state sequence is IDLE → READ_L1 → WAIT_L1 → READ_L2 → WAIT_L2 → DONE → IDLE. A top-level fault leaves WAIT_L1 directly for DONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Write strobe for the top-level table base |
| base_wdata | input | 32 | New top-level table base |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Walker idle, request accepted |
| mem_req | output | 1 | Memory read request, one cycle |
| mem_addr | output | 32 | Memory read byte address |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data (page table entry) |
| rsp_done | output | 1 | Walk complete, one cycle |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_flvl | output | 1 | Faulting level: 0 top-level, 1 second-level |

## Verification
A corrupted state register shows up at the memory port within a cycle or two. It appears as a missing, doubled or stretched `mem_req`, a wrong read address, or a second-level read after an absent top-level entry. A wrong captured table base or virtual address appears at the next read address or in `rsp_paddr` when `rsp_done` pulses. A base register that can change during a walk shows on the first read of the following walk. The bench therefore logs every read address and counts reads per walk, using memory latencies from zero to three wait cycles.

// File: rtl/walk_pkg.sv
package walk_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_READ_L1,
        S_WAIT_L1,
        S_READ_L2,
        S_WAIT_L2,
        S_DONE
    } walk_state_e;
endpackage

// File: rtl/walk_basereg.sv
module walk_basereg #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idle,
    input  logic          we,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] base_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= '0;
        else if (we && idle)
            base_q <= wdata;
    end

    // R10: the base cannot move while a walk is running
    a_r10_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(base_q));
endmodule

// File: rtl/walk_addrgen.sv
module walk_addrgen
    import walk_pkg::*;
#(
    parameter int AW    = 32,
    parameter int VA_W  = 32,
    parameter int IDX_W = 10,
    parameter int OFF_W = 12,
    parameter int PTE_W = 32
) (
    input  walk_state_e          state,
    input  logic [AW-1:0]        base_q,
    input  logic [VA_W-1:0]      vaddr_q,
    input  logic [PTE_W-OFF_W-1:0] tbl_q,
    output logic [AW-1:0]        mem_addr
);
    localparam int TOP_W    = VA_W - OFF_W - IDX_W;
    localparam int ENTRY_SH = $clog2(PTE_W / 8);

    logic [TOP_W-1:0] idx_top;
    logic [IDX_W-1:0] idx_sec;
    logic [AW-1:0]    l1_addr;
    logic [AW-1:0]    l2_addr;

    assign idx_top = vaddr_q[VA_W-1 -: TOP_W];
    assign idx_sec = vaddr_q[OFF_W +: IDX_W];
    assign l1_addr = base_q + (AW'(idx_top) << ENTRY_SH);
    assign l2_addr = AW'({tbl_q, {OFF_W{1'b0}}}) + (AW'(idx_sec) << ENTRY_SH);

    always_comb begin
        mem_addr = l1_addr;
        if (state == S_READ_L2 || state == S_WAIT_L2)
            mem_addr = l2_addr;
    end
endmodule

// File: rtl/walk_fsm.sv
module walk_fsm
    import walk_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int PTE_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [VA_W-1:0]        req_vaddr,
    input  logic                   mem_rvalid,
    input  logic [PTE_W-1:0]       mem_rdata,
    output walk_state_e            state,
    output logic [VA_W-1:0]        vaddr_q,
    output logic [PTE_W-OFF_W-1:0] tbl_q,
    output logic                   req_ready,
    output logic                   mem_req,
    output logic                   rsp_done,
    output logic [PTE_W-1:0]       rsp_paddr,
    output logic                   rsp_fault,
    output logic                   rsp_flvl
);
    localparam int FRM_W = PTE_W - OFF_W;

    walk_state_e nxt;
    logic        present;

    assign present = mem_rdata[0];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (req_valid) nxt = S_READ_L1;
            S_READ_L1: nxt = S_WAIT_L1;
            S_WAIT_L1: if (mem_rvalid) nxt = present ? S_READ_L2 : S_DONE;
            S_READ_L2: nxt = S_WAIT_L2;
            S_WAIT_L2: if (mem_rvalid) nxt = S_DONE;
            S_DONE:    nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // captured walk data and result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q   <= '0;
            tbl_q     <= '0;
            rsp_paddr <= '0;
            rsp_fault <= 1'b0;
            rsp_flvl  <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) vaddr_q <= req_vaddr;
                S_WAIT_L1: if (mem_rvalid) begin
                    if (present) begin
                        tbl_q <= mem_rdata[PTE_W-1 -: FRM_W];
                    end else begin
                        rsp_paddr <= '0;
                        rsp_fault <= 1'b1;
                        rsp_flvl  <= 1'b0;
                    end
                end
                S_WAIT_L2: if (mem_rvalid) begin
                    rsp_flvl <= 1'b1;
                    if (present) begin
                        rsp_paddr <= {mem_rdata[PTE_W-1 -: FRM_W], vaddr_q[OFF_W-1:0]};
                        rsp_fault <= 1'b0;
                        rsp_flvl  <= 1'b0;
                    end else begin
                        rsp_paddr <= '0;
                        rsp_fault <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready = (state == S_IDLE);
        mem_req   = (state == S_READ_L1) || (state == S_READ_L2);
        rsp_done  = (state == S_DONE);
    end

    a_r2_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> (!rsp_done && req_ready));
    a_r7_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT_L1 && !mem_rvalid) |=> state == S_WAIT_L1);
    a_r6_fault_zero_pa: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_fault) |-> rsp_paddr == '0);
    a_r9_vaddr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> $stable(vaddr_q));
    a_r11_l2_after_l1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_READ_L2) |-> $past(state) == S_WAIT_L1);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import walk_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int IDX_W = 10,
    parameter int OFF_W = 12,
    parameter int PTE_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_we,
    input  logic [PTE_W-1:0] base_wdata,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             req_ready,
    output logic             mem_req,
    output logic [PTE_W-1:0] mem_addr,
    input  logic             mem_rvalid,
    input  logic [PTE_W-1:0] mem_rdata,
    output logic             rsp_done,
    output logic [PTE_W-1:0] rsp_paddr,
    output logic             rsp_fault,
    output logic             rsp_flvl
);
    localparam int FRM_W = PTE_W - OFF_W;

    walk_state_e      state;
    logic [VA_W-1:0]  vaddr_q;
    logic [FRM_W-1:0] tbl_q;
    logic [PTE_W-1:0] base_q;

    walk_basereg #(.AW(PTE_W)) u_base (
        .clk    (clk),
        .rst_n  (rst_n),
        .idle   (req_ready),
        .we     (base_we),
        .wdata  (base_wdata),
        .base_q (base_q)
    );

    walk_fsm #(.VA_W(VA_W), .OFF_W(OFF_W), .PTE_W(PTE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_vaddr  (req_vaddr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .state      (state),
        .vaddr_q    (vaddr_q),
        .tbl_q      (tbl_q),
        .req_ready  (req_ready),
        .mem_req    (mem_req),
        .rsp_done   (rsp_done),
        .rsp_paddr  (rsp_paddr),
        .rsp_fault  (rsp_fault),
        .rsp_flvl   (rsp_flvl)
    );

    walk_addrgen #(.AW(PTE_W), .VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .PTE_W(PTE_W)) u_addr (
        .state    (state),
        .base_q   (base_q),
        .vaddr_q  (vaddr_q),
        .tbl_q    (tbl_q),
        .mem_addr (mem_addr)
    );
endmodule

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready, mem_req, rsp_done, rsp_fault, rsp_flvl;
    logic [31:0] mem_addr, rsp_paddr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = 32'hDEAD_BEE0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [31:0] mem [logic [31:0]];
    int          lat_cfg = 0;
    int          rd_cnt = 0;
    logic [31:0] rd_addr [4];

    always #2 clk = ~clk;

    pt_walker dut_i (
        .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .rsp_done(rsp_done), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .rsp_flvl(rsp_flvl)
    );

    // vector table: vaddr, wait cycles, paddr, fault, level, reads, 1st/2nd address
    localparam logic [31:0] V_VA [5] = '{32'h0040_5123, 32'h0040_6FFF, 32'h0080_0000, 32'h00FF_FABC, 32'h0000_0010};
    localparam int          V_LAT[5] = '{0, 2, 1, 3, 0};
    localparam logic [31:0] V_PA [5] = '{32'hABCD_E123, 32'h0, 32'h0, 32'hFFFF_FABC, 32'h0};
    localparam logic        V_F  [5] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
    localparam logic        V_LV [5] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
    localparam int          V_RD [5] = '{2, 2, 1, 2, 1};
    localparam logic [31:0] V_A1 [5] = '{32'h0001_0004, 32'h0001_0004, 32'h0001_0008, 32'h0001_000C, 32'h0001_0000};
    localparam logic [31:0] V_A2 [5] = '{32'h0002_0014, 32'h0002_0018, 32'h0, 32'h0003_0FFC, 32'h0};

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // memory responder: at least one cycle after the request, plus lat_cfg waits
    initial begin
        forever begin
            if (mem_req === 1'b1) begin
                automatic logic [31:0] a = mem_addr;
                if (rd_cnt < 4) rd_addr[rd_cnt] = a;
                rd_cnt++;
                @(negedge clk);
                repeat (lat_cfg) @(negedge clk);
                mem_rdata  = mem.exists(a) ? mem[a] : 32'h0;
                mem_rvalid = 1'b1;
                @(negedge clk);
                mem_rvalid = 1'b0;
                mem_rdata  = 32'hDEAD_BEE1;
            end else begin
                @(negedge clk);
            end
        end
    end

    task automatic start(input logic [31:0] va, input int lat);
        lat_cfg = lat;
        rd_cnt  = 0;
        req_valid = 1'b1;
        req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_walk(input string rq);
        int t = 0;
        while (rsp_done !== 1'b1 && t < 100) begin
            @(negedge clk);
            t++;
        end
        if (t >= 100) begin
            n_chk++; n_fail++;
            $display("FAIL %s actual=timeout expected=done", rq);
        end
    endtask

    task automatic set_base(input logic [31:0] b);
        base_we = 1'b1; base_wdata = b;
        @(negedge clk);
        base_we = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        mem[32'h0001_0004] = 32'h0002_0001;
        mem[32'h0001_000C] = 32'h0003_0001;
        mem[32'h0002_0014] = 32'hABCD_E001;
        mem[32'h0002_0018] = 32'h1234_5000;
        mem[32'h0003_0FFC] = 32'hFFFF_F001;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", {31'b0, req_ready}, 32'd1);
        chk("R1 done", {31'b0, rsp_done}, 32'd0);
        chk("R1 mem_req", {31'b0, mem_req}, 32'd0);

        set_base(32'h0001_0000);

        // table of vectors: R2 R3 R4 R5 R6 R7 R11
        for (int i = 0; i < 5; i++) begin
            start(V_VA[i], V_LAT[i]);
            finish_walk("R11 walk");
            chk("R4/R6 paddr", rsp_paddr, V_PA[i]);
            chk("R5/R6 fault", {31'b0, rsp_fault}, {31'b0, V_F[i]});
            chk("R5/R6 level", {31'b0, rsp_flvl}, {31'b0, V_LV[i]});
            chk("R2 first addr", rd_addr[0], V_A1[i]);
            if (V_RD[i] == 2) chk("R3 second addr", rd_addr[1], V_A2[i]);
            chk("R5 read count", rd_cnt, V_RD[i]);
            @(negedge clk);
            // R8 done is one cycle, back in idle
            chk("R8 done drop", {31'b0, rsp_done}, 32'd0);
            chk("R8 ready", {31'b0, req_ready}, 32'd1);
        end

        // R9 / R10: request and base write during a walk are ignored
        start(V_VA[0], 3);
        base_we = 1'b1; base_wdata = 32'h0005_0000;
        req_valid = 1'b1; req_vaddr = 32'h00C0_0000;
        repeat (2) @(negedge clk);
        base_we = 1'b0; req_valid = 1'b0;
        finish_walk("R9 walk");
        chk("R9 paddr kept", rsp_paddr, 32'hABCD_E123);
        chk("R9 first addr", rd_addr[0], 32'h0001_0004);
        repeat (4) @(negedge clk);
        chk("R9 no extra walk", rd_cnt, 2);
        start(V_VA[4], 0);
        finish_walk("R10 walk");
        chk("R10 base not written while busy", rd_addr[0], 32'h0001_0000);
        @(negedge clk);

        // R10: idle write takes effect
        set_base(32'h0004_0000);
        start(32'h0040_0000, 1);
        finish_walk("R10 walk2");
        chk("R10 new base addr", rd_addr[0], 32'h0004_0004);
        chk("R10 fault level", {30'b0, rsp_fault, rsp_flvl}, 32'd2);
        @(negedge clk);

        // R10: write in the same cycle as an accepted request applies to it
        base_we = 1'b1; base_wdata = 32'h0001_0000;
        start(V_VA[0], 0);
        base_we = 1'b0;
        finish_walk("R10 walk3");
        chk("R10 same-cycle addr", rd_addr[0], 32'h0001_0004);
        chk("R10 same-cycle paddr", rsp_paddr, 32'hABCD_E123);
        @(negedge clk);

        summary();
    end
endmodule